// File: doc/BRIEF.md
# Segmented physical address generator

This block is a purely combinational address former for a 16-bit processor that uses segmented memory. Each cycle it takes the architectural register values, an addressing-mode code and a displacement. From these it produces three results: the 16-bit effective address (the offset inside a segment), the index of the default segment register, and the 20-bit physical address. The physical address is the chosen segment value shifted left by four bits plus the offset.

An execution or bus-interface stage drives the register file outputs and the decoded mode into the block and reads all three results in the same cycle. The block covers these accesses:

- memory operands in direct, register-indirect, based, indexed and based-indexed form;
- instruction fetch and short relative branch targets;
- stack pushes and pops;
- the source and destination of string moves.

Segment override prefixes and the memory access itself belong to the surrounding logic.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (value of the selected segment register × 16 + `ea_out`) modulo 2^20. For example, segment 89AB with offset F012 gives 98AC2, and segment FFFF with offset FFFF gives 0FFEF.
- R2: When `disp_short` is 1, the displacement used is `disp[7:0]` sign-extended to 16 bits (A2 becomes FFA2), and `disp[15:8]` has no effect. When `disp_short` is 0, all of `disp` is used.
- R3: Every effective-address sum wraps modulo 2^16 before the segment is added.
- R4: `seg_sel` encodes the segment as 0 = ES, 1 = CS, 2 = SS, 3 = DS. Mode 0 (direct) gives EA = displacement in DS. Modes 1, 2, 3 and 4 give EA = BX, BP, SI and DI respectively.
- R5: Based modes give EA = base + displacement: mode 5 uses BX and mode 6 uses BP.
- R6: Indexed modes give EA = index + displacement: mode 7 uses SI and mode 8 uses DI. Both use DS.
- R7: Based-indexed modes give EA = base + index + displacement: 9 is BX+SI, 10 is BX+DI, 11 is BP+SI and 12 is BP+DI.
- R8: Every mode whose base is BP (modes 2, 6, 11 and 12) selects SS. Modes 0, 1, 3, 4, 5, 9 and 10 select DS.
- R9: Mode 13 (fetch) gives EA = IP in CS. Mode 14 (relative) gives EA = IP + sign-extended `disp[7:0]` in CS, whatever the value of `disp_short`.
- R10: Mode 17 (push) gives EA = SP − 2 in SS. Mode 18 (pop) gives EA = SP in SS.
- R11: Mode 15 (string source) gives EA = SI in DS. Mode 16 (string destination) gives EA = DI in ES.
- R12: Mode codes 19 to 31 give EA = 0 and select DS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| seg_es | input | 16 | Extra segment register value |
| seg_cs | input | 16 | Code segment register value |
| seg_ss | input | 16 | Stack segment register value |
| seg_ds | input | 16 | Data segment register value |
| reg_bx | input | 16 | Base register BX |
| reg_bp | input | 16 | Base pointer BP |
| reg_si | input | 16 | Source index SI |
| reg_di | input | 16 | Destination index DI |
| reg_sp | input | 16 | Stack pointer SP |
| reg_ip | input | 16 | Instruction pointer IP |
| mode | input | 5 | Addressing-mode code (see requirements) |
| disp | input | 16 | Displacement; only bits 7:0 count when short |
| disp_short | input | 1 | 1 = sign-extend the low displacement byte |
| ea_out | output | 16 | Effective address |
| seg_sel | output | 2 | Selected segment index |
| phys_addr | output | 20 | Physical address |

## Verification
No register lies between any input and the three outputs, so every result is due in the same cycle as its stimulus. The bench changes all inputs together on the falling clock edge and samples a few nanoseconds later, well before the next rising edge, so it never reads a half-settled value. The vector walk covers every mode code with fixed register contents. Directed cases then cover 16-bit and 20-bit wraparound, the ignored upper displacement byte, and the all-zero state after reset.

// File: rtl/sag_pkg.sv
package sag_pkg;

   typedef enum logic [1:0] {
      SEG_ES = 2'd0,
      SEG_CS = 2'd1,
      SEG_SS = 2'd2,
      SEG_DS = 2'd3
   } seg_idx_t;

   localparam int MODE_W = 5;

   typedef enum logic [MODE_W-1:0] {
      AM_DIRECT  = 5'd0,
      AM_IND_BX  = 5'd1,
      AM_IND_BP  = 5'd2,
      AM_IND_SI  = 5'd3,
      AM_IND_DI  = 5'd4,
      AM_BAS_BX  = 5'd5,
      AM_BAS_BP  = 5'd6,
      AM_IDX_SI  = 5'd7,
      AM_IDX_DI  = 5'd8,
      AM_BX_SI   = 5'd9,
      AM_BX_DI   = 5'd10,
      AM_BP_SI   = 5'd11,
      AM_BP_DI   = 5'd12,
      AM_FETCH   = 5'd13,
      AM_REL     = 5'd14,
      AM_STR_SRC = 5'd15,
      AM_STR_DST = 5'd16,
      AM_PUSH    = 5'd17,
      AM_POP     = 5'd18
   } amode_t;

   localparam int NUM_SEG = 4;

endpackage

// File: rtl/sag_disp_ext.sv
module sag_disp_ext #(
   parameter int OFS_W   = 16,
   parameter int SHORT_W = 8
) (
   input  logic [OFS_W-1:0] disp_raw,
   input  logic             short_sel,
   output logic [OFS_W-1:0] disp_sel,
   output logic [OFS_W-1:0] disp_short_ext
);
   localparam int PAD_W = OFS_W - SHORT_W;

   generate
      if (PAD_W > 0) begin : g_pad
         assign disp_short_ext = {{PAD_W{disp_raw[SHORT_W-1]}}, disp_raw[SHORT_W-1:0]};
      end else begin : g_nopad
         assign disp_short_ext = disp_raw;
      end
   endgenerate

   assign disp_sel = short_sel ? disp_short_ext : disp_raw;
endmodule

// File: rtl/sag_offset_unit.sv
module sag_offset_unit
   import sag_pkg::*;
#(
   parameter int OFS_W     = 16,
   parameter int STACK_STEP = 2
) (
   input  logic [MODE_W-1:0] mode_code,
   input  logic [OFS_W-1:0]  bx,
   input  logic [OFS_W-1:0]  bp,
   input  logic [OFS_W-1:0]  si,
   input  logic [OFS_W-1:0]  di,
   input  logic [OFS_W-1:0]  sp,
   input  logic [OFS_W-1:0]  ip,
   input  logic [OFS_W-1:0]  dsp,
   input  logic [OFS_W-1:0]  dsp_rel,
   output logic [OFS_W-1:0]  ea,
   output seg_idx_t          seg
);
   localparam logic [OFS_W-1:0] STEP = OFS_W'(STACK_STEP);

   logic [OFS_W-1:0] base_v;
   logic [OFS_W-1:0] index_v;
   logic [OFS_W-1:0] add_v;

   // operand selection: ea = base + index + add, all modulo 2^OFS_W
   always_comb begin
      base_v  = '0;
      index_v = '0;
      add_v   = '0;
      seg     = SEG_DS;
      unique case (mode_code)
         AM_DIRECT:  add_v = dsp;
         AM_IND_BX:  base_v = bx;
         AM_IND_BP:  begin base_v = bp; seg = SEG_SS; end
         AM_IND_SI:  index_v = si;
         AM_IND_DI:  index_v = di;
         AM_BAS_BX:  begin base_v = bx; add_v = dsp; end
         AM_BAS_BP:  begin base_v = bp; add_v = dsp; seg = SEG_SS; end
         AM_IDX_SI:  begin index_v = si; add_v = dsp; end
         AM_IDX_DI:  begin index_v = di; add_v = dsp; end
         AM_BX_SI:   begin base_v = bx; index_v = si; add_v = dsp; end
         AM_BX_DI:   begin base_v = bx; index_v = di; add_v = dsp; end
         AM_BP_SI:   begin base_v = bp; index_v = si; add_v = dsp; seg = SEG_SS; end
         AM_BP_DI:   begin base_v = bp; index_v = di; add_v = dsp; seg = SEG_SS; end
         AM_FETCH:   begin base_v = ip; seg = SEG_CS; end
         AM_REL:     begin base_v = ip; add_v = dsp_rel; seg = SEG_CS; end
         AM_STR_SRC: index_v = si;
         AM_STR_DST: begin index_v = di; seg = SEG_ES; end
         AM_PUSH:    begin base_v = sp; add_v = ~STEP + 1'b1; seg = SEG_SS; end
         AM_POP:     begin base_v = sp; seg = SEG_SS; end
         default:    ;
      endcase
   end

   assign ea = base_v + index_v + add_v;
endmodule

// File: rtl/sag_seg_mux.sv
module sag_seg_mux
   import sag_pkg::*;
#(
   parameter int OFS_W = 16
) (
   input  logic [NUM_SEG*OFS_W-1:0] seg_bus,
   input  seg_idx_t                 sel,
   output logic [OFS_W-1:0]         seg_val
);
   logic [OFS_W-1:0] bank [NUM_SEG];

   generate
      for (genvar g = 0; g < NUM_SEG; g++) begin : g_bank
         assign bank[g] = seg_bus[g*OFS_W +: OFS_W];
      end
   endgenerate

   assign seg_val = bank[sel];
endmodule

// File: rtl/sag_phys_add.sv
module sag_phys_add #(
   parameter int OFS_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int PHYS_W    = 20
) (
   input  logic [OFS_W-1:0]  seg_val,
   input  logic [OFS_W-1:0]  ofs,
   output logic [PHYS_W-1:0] pa
);
   localparam int SUM_W = OFS_W + SEG_SHIFT + 1;

   logic [SUM_W-1:0] sum;
   assign sum = {1'b0, seg_val, {SEG_SHIFT{1'b0}}} + SUM_W'(ofs);

   generate
      if (PHYS_W >= SUM_W) begin : g_keep_carry
         assign pa = PHYS_W'(sum);
      end else begin : g_wrap
         assign pa = sum[PHYS_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import sag_pkg::*;
#(
   parameter int OFS_W      = 16,
   parameter int SEG_SHIFT  = 4,
   parameter int PHYS_W     = 20,
   parameter int SHORT_W    = 8,
   parameter int STACK_STEP = 2
) (
   input  logic [OFS_W-1:0]  seg_es,
   input  logic [OFS_W-1:0]  seg_cs,
   input  logic [OFS_W-1:0]  seg_ss,
   input  logic [OFS_W-1:0]  seg_ds,
   input  logic [OFS_W-1:0]  reg_bx,
   input  logic [OFS_W-1:0]  reg_bp,
   input  logic [OFS_W-1:0]  reg_si,
   input  logic [OFS_W-1:0]  reg_di,
   input  logic [OFS_W-1:0]  reg_sp,
   input  logic [OFS_W-1:0]  reg_ip,
   input  logic [MODE_W-1:0] mode,
   input  logic [OFS_W-1:0]  disp,
   input  logic              disp_short,
   output logic [OFS_W-1:0]  ea_out,
   output logic [1:0]        seg_sel,
   output logic [PHYS_W-1:0] phys_addr
);
   generate
      if (SHORT_W < 1 || SHORT_W > OFS_W) begin : g_bad_short
         $error("SHORT_W must lie in 1..OFS_W");
      end
      if (PHYS_W < OFS_W) begin : g_bad_phys
         $error("PHYS_W must be at least OFS_W");
      end
      if (STACK_STEP < 1 || STACK_STEP >= (1 << (OFS_W - 1))) begin : g_bad_step
         $error("STACK_STEP out of range");
      end
   endgenerate

   logic [OFS_W-1:0] dsp_sel;
   logic [OFS_W-1:0] dsp_sx;
   logic [OFS_W-1:0] ea_w;
   logic [OFS_W-1:0] segv;
   seg_idx_t         seg_w;

   sag_disp_ext #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_disp (
      .disp_raw      (disp),
      .short_sel     (disp_short),
      .disp_sel      (dsp_sel),
      .disp_short_ext(dsp_sx)
   );

   sag_offset_unit #(.OFS_W(OFS_W), .STACK_STEP(STACK_STEP)) u_ofs (
      .mode_code(mode),
      .bx       (reg_bx),
      .bp       (reg_bp),
      .si       (reg_si),
      .di       (reg_di),
      .sp       (reg_sp),
      .ip       (reg_ip),
      .dsp      (dsp_sel),
      .dsp_rel  (dsp_sx),
      .ea       (ea_w),
      .seg      (seg_w)
   );

   sag_seg_mux #(.OFS_W(OFS_W)) u_mux (
      .seg_bus({seg_ds, seg_ss, seg_cs, seg_es}),
      .sel    (seg_w),
      .seg_val(segv)
   );

   sag_phys_add #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .PHYS_W(PHYS_W)) u_pa (
      .seg_val(segv),
      .ofs    (ea_w),
      .pa     (phys_addr)
   );

   assign ea_out  = ea_w;
   assign seg_sel = seg_w;
endmodule

// File: rtl/sag_check.sv
module sag_check #(
   parameter int OFS_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int PHYS_W    = 20,
   parameter int SHORT_W   = 8
) (
   input logic [OFS_W-1:0]  seg_es,
   input logic [OFS_W-1:0]  seg_cs,
   input logic [OFS_W-1:0]  seg_ss,
   input logic [OFS_W-1:0]  seg_ds,
   input logic [OFS_W-1:0]  reg_sp,
   input logic [OFS_W-1:0]  reg_si,
   input logic [OFS_W-1:0]  reg_di,
   input logic [4:0]        mode,
   input logic [OFS_W-1:0]  disp,
   input logic              disp_short,
   input logic [OFS_W-1:0]  ea_out,
   input logic [1:0]        seg_sel,
   input logic [PHYS_W-1:0] phys_addr
);
   logic [OFS_W-1:0]   chosen;
   logic [OFS_W+SEG_SHIFT:0] full;

   always_comb begin
      case (seg_sel)
         2'd0:    chosen = seg_es;
         2'd1:    chosen = seg_cs;
         2'd2:    chosen = seg_ss;
         default: chosen = seg_ds;
      endcase
      full = {1'b0, chosen, {SEG_SHIFT{1'b0}}} + (OFS_W+SEG_SHIFT+1)'(ea_out);
   end

   always_comb begin
      if (!$isunknown({mode, seg_sel, ea_out, phys_addr, disp, disp_short})) begin
         // R1
         phys_matches_seg_chk: assert (phys_addr == PHYS_W'(full));
         // R8
         bp_base_uses_ss_chk: assert (!(mode == 5'd2 || mode == 5'd6 || mode == 5'd11 || mode == 5'd12)
                                      || seg_sel == 2'd2);
         // R9
         code_modes_use_cs_chk: assert (!(mode == 5'd13 || mode == 5'd14) || seg_sel == 2'd1);
         // R11
         string_dst_es_chk: assert (mode != 5'd16 || (seg_sel == 2'd0 && ea_out == reg_di));
         // R11
         string_src_ds_chk: assert (mode != 5'd15 || (seg_sel == 2'd3 && ea_out == reg_si));
         // R2
         short_disp_sext_chk: assert (!(mode == 5'd0 && disp_short)
                                      || (ea_out[SHORT_W-1:0] == disp[SHORT_W-1:0]
                                          && (&ea_out[OFS_W-1:SHORT_W-1] || ~|ea_out[OFS_W-1:SHORT_W-1])));
         // R10
         push_predecrement_chk: assert (mode != 5'd17 || (ea_out == reg_sp - OFS_W'(2) && seg_sel == 2'd2));
         // R12
         undefined_mode_zero_chk: assert (mode < 5'd19 || (ea_out == '0 && seg_sel == 2'd3));
      end
   end
endmodule

bind seg_addr_gen sag_check #(
   .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .PHYS_W(PHYS_W), .SHORT_W(SHORT_W)
) u_sag_check (
   .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
   .reg_sp(reg_sp), .reg_si(reg_si), .reg_di(reg_di),
   .mode(mode), .disp(disp), .disp_short(disp_short),
   .ea_out(ea_out), .seg_sel(seg_sel), .phys_addr(phys_addr)
);

// File: tb/tb_seg_addr_gen.sv
`timescale 1ns/1ps
module tb_seg_addr_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
   logic [15:0] reg_bx, reg_bp, reg_si, reg_di, reg_sp, reg_ip;
   logic [4:0]  mode;
   logic [15:0] disp;
   logic        disp_short;
   logic [15:0] ea_out;
   logic [1:0]  seg_sel;
   logic [19:0] phys_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   seg_addr_gen dut (
      .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
      .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
      .reg_sp(reg_sp), .reg_ip(reg_ip), .mode(mode), .disp(disp),
      .disp_short(disp_short), .ea_out(ea_out), .seg_sel(seg_sel),
      .phys_addr(phys_addr)
   );

   // {mode, disp, short, expected ea, expected segment}
   localparam int NV = 21;
   localparam logic [39:0] VEC [NV] = '{
      {5'd0,  16'h1234, 1'b0, 16'h1234, 2'd3},  // R4 direct
      {5'd0,  16'hABA2, 1'b1, 16'hFFA2, 2'd3},  // R2 short, high byte ignored
      {5'd1,  16'h0012, 1'b0, 16'h1000, 2'd3},  // R4
      {5'd2,  16'h0012, 1'b0, 16'h2000, 2'd2},  // R8
      {5'd3,  16'h0012, 1'b0, 16'h0030, 2'd3},  // R4
      {5'd4,  16'h0012, 1'b0, 16'h0040, 2'd3},  // R4
      {5'd5,  16'h0008, 1'b1, 16'h1008, 2'd3},  // R5
      {5'd6,  16'h00F0, 1'b1, 16'h1FF0, 2'd2},  // R5 R8
      {5'd7,  16'h00A2, 1'b1, 16'hFFD2, 2'd3},  // R6
      {5'd8,  16'h0100, 1'b0, 16'h0140, 2'd3},  // R6
      {5'd9,  16'h000A, 1'b1, 16'h103A, 2'd3},  // R7
      {5'd10, 16'h0000, 1'b0, 16'h1040, 2'd3},  // R7
      {5'd11, 16'h0005, 1'b0, 16'h2035, 2'd2},  // R7 R8
      {5'd12, 16'hFFFF, 1'b0, 16'h203F, 2'd2},  // R7 R8
      {5'd13, 16'h0012, 1'b0, 16'h0200, 2'd1},  // R9 fetch
      {5'd14, 16'h55F6, 1'b0, 16'h01F6, 2'd1},  // R9 relative, flag ignored
      {5'd15, 16'h0012, 1'b0, 16'h0030, 2'd3},  // R11
      {5'd16, 16'h0012, 1'b0, 16'h0040, 2'd0},  // R11
      {5'd17, 16'h0012, 1'b0, 16'h00FE, 2'd2},  // R10 push
      {5'd18, 16'h0012, 1'b0, 16'h0100, 2'd2},  // R10 pop
      {5'd25, 16'h0012, 1'b0, 16'h0000, 2'd3}   // R12
   };

   function automatic logic [15:0] seg_of(input logic [1:0] s);
      case (s)
         2'd0:    return seg_es;
         2'd1:    return seg_cs;
         2'd2:    return seg_ss;
         default: return seg_ds;
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] exp_ea,
                        input logic [1:0] exp_seg, input logic [19:0] exp_pa);
      n_checks++;
      if (ea_out !== exp_ea || seg_sel !== exp_seg || phys_addr !== exp_pa) begin
         n_fail++;
         $display("FAIL %s mode=%0d: ea=%h seg=%0d pa=%h expected ea=%h seg=%0d pa=%h",
                  req, mode, ea_out, seg_sel, phys_addr, exp_ea, exp_seg, exp_pa);
      end
   endtask

   task automatic apply(input logic [4:0] m, input logic [15:0] d, input logic s);
      @(negedge clk);
      mode = m; disp = d; disp_short = s;
      #2;
   endtask

   task automatic std_regs();
      seg_es = 16'h1000; seg_cs = 16'h2000; seg_ss = 16'h3000; seg_ds = 16'h4000;
      reg_bx = 16'h1000; reg_bp = 16'h2000; reg_si = 16'h0030; reg_di = 16'h0040;
      reg_sp = 16'h0100; reg_ip = 16'h0200;
   endtask

   initial begin
      seg_es = '0; seg_cs = '0; seg_ss = '0; seg_ds = '0;
      reg_bx = '0; reg_bp = '0; reg_si = '0; reg_di = '0; reg_sp = '0; reg_ip = '0;
      mode = '0; disp = '0; disp_short = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      // R4 all-zero state after reset: direct, zero displacement, DS
      check("R4", 16'h0000, 2'd3, 20'h00000);

      std_regs();
      for (int i = 0; i < NV; i++) begin
         logic [15:0] e;
         logic [1:0]  s;
         apply(VEC[i][39:35], VEC[i][34:19], VEC[i][18]);
         e = VEC[i][17:2];
         s = VEC[i][1:0];
         // R1 physical address from the expected segment and offset
         check($sformatf("R1/vec%0d", i), e, s, {seg_of(s), 4'h0} + {4'h0, e});
      end

      // R1 worked example 89AB:F012
      seg_ds = 16'h89AB;
      apply(5'd0, 16'hF012, 1'b0);
      check("R1", 16'hF012, 2'd3, 20'h98AC2);
      // R1 20-bit wrap
      seg_ds = 16'hFFFF;
      apply(5'd0, 16'hFFFF, 1'b0);
      check("R1", 16'hFFFF, 2'd3, 20'h0FFEF);
      // R3 16-bit wrap of base+index+disp
      seg_ds = 16'h4000; reg_bx = 16'hFFFF; reg_si = 16'h0002;
      apply(5'd9, 16'h0001, 1'b0);
      check("R3", 16'h0002, 2'd3, 20'h40002);
      // R2 high byte changed under short flag: no effect
      std_regs();
      apply(5'd5, 16'h7780, 1'b1);
      check("R2", 16'h0F80, 2'd3, 20'h40000 + 20'h0F80);
      // R10 push from SP=0 wraps
      reg_sp = 16'h0000;
      apply(5'd17, 16'h0000, 1'b0);
      check("R10", 16'hFFFE, 2'd2, 20'h30000 + 20'hFFFE);
      // R12 highest code
      apply(5'd31, 16'h1234, 1'b1);
      check("R12", 16'h0000, 2'd3, 20'h40000);
      // R9 relative with positive byte and long flag
      apply(5'd14, 16'hFF7F, 1'b0);
      check("R9", 16'h027F, 2'd1, 20'h20000 + 20'h027F);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule